// File: doc/BRIEF.md
# SDRAM Presence-Detect Image Generator

This block builds the 256-byte presence-detect image that a memory module would carry in its configuration EEPROM. Software or a boot sequencer pulses `start` with a memory generation (SDR, DDR or DDR2) and a module capacity in megabytes. The block normalises the capacity to a power of two, moves to a different generation when the capacity is too small for the requested one, and splits the capacity across up to eight banks. It then encodes the per-bank density in the bit layout that the chosen generation uses.

The image is written into an internal byte RAM, one byte per clock, in ascending address order. While the bytes below the checksum slot are written, their modulo-256 sum is accumulated. That sum is stored in the checksum slot. `done` rises once the last byte is in place. Four flags report the outcome: capacity too small, capacity not a power of two, generation changed, and capacity truncated by the bank limit. A registered byte read port exposes the finished image, for example to an EEPROM responder on a management bus.

Top module: `spd_image_gen`

## Requirements
- R1: After reset, `busy`, `done`, `err_small`, `warn_npow2`, `warn_retype` and `warn_trunc` are all 0.
- R2: A `start` sampled while idle or finished raises `busy` after that edge. For a valid capacity, `done` rises on the 257th rising edge after the sampling edge, and `busy` falls on the same edge.
- R3: A capacity below 4 MB sets `err_small` and `done` on the first edge after the sampling edge. The other three flags stay 0 and the RAM contents are left unchanged.
- R4: The capacity is floored to the highest power of two not above it. `warn_npow2` is set when any lower bits were dropped.
- R5: `mem_type` encodes 0 = SDR, 1 = DDR, 2 = DDR2, and 3 acts as DDR2. The per-bank log2 MB ranges are SDR 2..9, DDR 5..12 and DDR2 7..14. When the floored log2 is below the minimum of the requested generation, the generation becomes DDR if the capacity is at least 32 MB and SDR otherwise, and `warn_retype` is set.
- R6: The bank count starts at 1. While log2 is above the generation maximum and there are fewer than 8 banks, log2 drops by one and the bank count rises by one. `warn_trunc` is set when the floored capacity exceeds 2^log2 × banks.
- R7: If the result is a single bank and log2 is above the generation minimum, the capacity is split into two banks of half size.
- R8: Byte 31 holds the density d = 1 << (log2 − 2), folded by generation: DDR2 gives (d & 0xE0) | ((d >> 8) & 0x1F), DDR gives (d & 0xF8) | ((d >> 8) & 0x07), and SDR gives d & 0xFF.
- R9: Byte 2 holds the generation code (SDR 4, DDR 7, DDR2 8). Byte 5 holds the bank count, minus one for DDR2. Bytes 15 and 19 are 0 for DDR2 and 1 otherwise. The fixed bytes are 0:128, 1:8, 3:13, 4:10, 6:64, 8:4, 9:0x25, 10:1, 12:0x82, 13:8, 16:12, 17:4, 18:12, 20:2, 23:0x12, 27:20, 28:15, 29:20, 30:45, 32:20, 33:8, 34:20 and 35:8. Every other byte except 31 and 63 is 0.
- R10: Byte 63 holds the modulo-256 sum of bytes 0 to 62.
- R11: A `start` that arrives while `busy` is high is ignored, and the image finishes from the original inputs.
- R12: `rd_data` shows the RAM byte at the `rd_addr` sampled on the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to build an image |
| mem_type | input | 2 | Requested memory generation |
| size_mb | input | SIZE_W | Module capacity in megabytes |
| rd_addr | input | ADDR_W | Image byte address to read |
| rd_data | output | 8 | Image byte, one cycle after the address |
| busy | output | 1 | Image build in progress |
| done | output | 1 | Last build finished (held until the next start) |
| err_small | output | 1 | Capacity below 4 MB; no image written |
| warn_npow2 | output | 1 | Capacity was not a power of two |
| warn_retype | output | 1 | Generation was changed to fit the capacity |
| warn_trunc | output | 1 | Capacity exceeds what eight banks can describe |

## Verification
The hardest corner to reach is the bank cap. There, log2 is still above the generation maximum when the eighth bank is added, and the density exceeds eight bits, so the SDR fold yields 0 in byte 31. The stimulus reaches it with a capacity of 2^17 MB on SDR. It also reaches the type fallback in both directions by asking for DDR2 with 64 MB and with 16 MB. The ignored restart is provoked by pulsing `start` with different inputs in the middle of a fill. Then both the cycle count to `done` and every image byte are checked against the first request.

// File: rtl/spd_gen_pkg.sv
package spd_gen_pkg;

    localparam int LG_W      = 5;
    localparam int BANK_W    = 4;
    localparam int MAX_BANKS = 8;
    localparam int CSUM_IDX  = 63;
    localparam int MIN_MB    = 4;
    localparam int RETYPE_MB = 32;

    typedef enum logic [1:0] {
        KIND_SDR  = 2'd0,
        KIND_DDR  = 2'd1,
        KIND_DDR2 = 2'd2,
        KIND_RSV  = 2'd3
    } mem_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CALC,
        ST_FILL,
        ST_FIN
    } gen_state_e;

    typedef struct packed {
        mem_kind_e          kind;
        logic [LG_W-1:0]    lg;
        logic [BANK_W-1:0]  banks;
        logic [7:0]         dens;
    } geom_t;

    typedef struct packed {
        logic too_small;
        logic npow2;
        logic retype;
        logic trunc;
    } flags_t;

    function automatic logic [LG_W-1:0] kind_min(mem_kind_e k);
        case (k)
            KIND_SDR: kind_min = LG_W'(2);
            KIND_DDR: kind_min = LG_W'(5);
            default:  kind_min = LG_W'(7);
        endcase
    endfunction

    function automatic logic [LG_W-1:0] kind_max(mem_kind_e k);
        case (k)
            KIND_SDR: kind_max = LG_W'(9);
            KIND_DDR: kind_max = LG_W'(12);
            default:  kind_max = LG_W'(14);
        endcase
    endfunction

    function automatic logic [7:0] kind_code(mem_kind_e k);
        case (k)
            KIND_SDR: kind_code = 8'd4;
            KIND_DDR: kind_code = 8'd7;
            default:  kind_code = 8'd8;
        endcase
    endfunction

    // Per-generation packing of the bank density into one byte.
    function automatic logic [7:0] fold_density(mem_kind_e k, logic [LG_W-1:0] lg);
        logic [31:0] d;
        d = 32'd1 << (lg - LG_W'(2));
        case (k)
            KIND_DDR2: fold_density = {d[7:5], d[12:8]};
            KIND_DDR:  fold_density = {d[7:3], d[10:8]};
            default:   fold_density = d[7:0];
        endcase
    endfunction

endpackage

// File: rtl/spd_size_norm.sv
module spd_size_norm
    import spd_gen_pkg::*;
#(
    parameter int SIZE_W = 20
) (
    input  mem_kind_e          kind_in,
    input  logic [SIZE_W-1:0]  size_in,
    output geom_t              geom,
    output flags_t             flags
);
    localparam int CAP_W = SIZE_W + BANK_W;

    logic [LG_W-1:0]   lg_full;
    logic [LG_W-1:0]   lg;
    logic [LG_W-1:0]   excess;
    logic [LG_W-1:0]   steps;
    logic [BANK_W-1:0] banks;
    logic [SIZE_W-1:0] pow;
    logic [CAP_W-1:0]  cap_full;
    logic [CAP_W-1:0]  cap_banks;
    mem_kind_e         kind;
    logic              small_n;

    always_comb begin
        // floor(log2(size)) by priority scan
        lg_full = '0;
        for (int i = 0; i < SIZE_W; i++) begin
            if (size_in[i]) lg_full = LG_W'(i);
        end
        pow          = '0;
        pow[lg_full] = 1'b1;
        small_n      = (size_in < SIZE_W'(MIN_MB));

        kind         = (kind_in == KIND_RSV) ? KIND_DDR2 : kind_in;
        flags        = '0;
        flags.npow2  = (size_in != pow);

        if (lg_full < kind_min(kind)) begin
            flags.retype = 1'b1;
            kind = (size_in >= SIZE_W'(RETYPE_MB)) ? KIND_DDR : KIND_SDR;
        end

        // bank spreading, capped at MAX_BANKS
        excess = (lg_full > kind_max(kind)) ? (lg_full - kind_max(kind)) : '0;
        steps  = (excess > LG_W'(MAX_BANKS - 1)) ? LG_W'(MAX_BANKS - 1) : excess;
        banks  = BANK_W'(1) + BANK_W'(steps);
        lg     = lg_full - steps;

        cap_full    = CAP_W'(1) << lg_full;
        cap_banks   = CAP_W'(banks) << lg;
        flags.trunc = (cap_full > cap_banks);

        // single bank with room below: split in two halves
        if ((banks == BANK_W'(1)) && (lg > kind_min(kind))) begin
            lg    = lg - LG_W'(1);
            banks = BANK_W'(2);
        end

        geom.kind  = kind;
        geom.lg    = lg;
        geom.banks = banks;
        geom.dens  = fold_density(kind, lg);

        if (small_n) begin
            flags = '0;
        end
        flags.too_small = small_n;

        if (!small_n) begin
            AST_BANKS_RANGE: assert (banks >= BANK_W'(1) && banks <= BANK_W'(MAX_BANKS)) else $error("bank count out of range"); // R6
            AST_LG_FLOOR: assert (lg >= kind_min(kind)) else $error("per-bank log2 below generation minimum"); // R5
        end
    end

endmodule

// File: rtl/spd_byte_rom.sv
module spd_byte_rom
    import spd_gen_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  geom_t             geom,
    output logic [7:0]        data
);
    logic is_ddr2;

    always_comb begin
        is_ddr2 = (geom.kind == KIND_DDR2);
        case (int'(addr))
            0:  data = 8'd128;
            1:  data = 8'd8;
            2:  data = kind_code(geom.kind);
            3:  data = 8'd13;
            4:  data = 8'd10;
            5:  data = 8'(geom.banks) - (is_ddr2 ? 8'd1 : 8'd0);
            6:  data = 8'd64;
            8:  data = 8'd4;
            9:  data = 8'h25;
            10: data = 8'd1;
            12: data = 8'h82;
            13: data = 8'd8;
            15: data = is_ddr2 ? 8'd0 : 8'd1;
            16: data = 8'd12;
            17: data = 8'd4;
            18: data = 8'd12;
            19: data = is_ddr2 ? 8'd0 : 8'd1;
            20: data = 8'd2;
            23: data = 8'h12;
            27: data = 8'd20;
            28: data = 8'd15;
            29: data = 8'd20;
            30: data = 8'd45;
            31: data = geom.dens;
            32: data = 8'd20;
            33: data = 8'd8;
            34: data = 8'd20;
            35: data = 8'd8;
            default: data = 8'd0;
        endcase
    end

endmodule

// File: rtl/spd_img_ram.sv
module spd_img_ram #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
        rd_data <= mem[rd_addr];
    end

endmodule

// File: rtl/spd_image_gen.sv
module spd_image_gen
    import spd_gen_pkg::*;
#(
    parameter int SIZE_W = 20,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        mem_type,
    input  logic [SIZE_W-1:0] size_mb,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic              done,
    output logic              err_small,
    output logic              warn_npow2,
    output logic              warn_retype,
    output logic              warn_trunc
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);
    localparam logic [ADDR_W-1:0] CSUM_ADDR = ADDR_W'(CSUM_IDX);

    gen_state_e        state;
    mem_kind_e         kind_q;
    logic [SIZE_W-1:0] size_q;
    geom_t             geom_n, geom_q;
    flags_t            flags_n, flags_q;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        sum_q;
    logic [7:0]        rom_byte;
    logic [7:0]        wr_data;
    logic              wr_en;

    spd_size_norm #(.SIZE_W(SIZE_W)) i_norm (
        .kind_in (kind_q),
        .size_in (size_q),
        .geom    (geom_n),
        .flags   (flags_n)
    );

    spd_byte_rom #(.ADDR_W(ADDR_W)) i_rom (
        .addr (wr_addr),
        .geom (geom_q),
        .data (rom_byte)
    );

    assign wr_en   = (state == ST_FILL);
    assign wr_data = (wr_addr == CSUM_ADDR) ? sum_q : rom_byte;

    spd_img_ram #(.ADDR_W(ADDR_W), .DATA_W(8)) i_ram (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            kind_q  <= KIND_SDR;
            size_q  <= '0;
            geom_q  <= '0;
            flags_q <= '0;
            wr_addr <= '0;
            sum_q   <= '0;
        end else begin
            case (state)
                ST_IDLE, ST_FIN: begin
                    if (start) begin
                        kind_q  <= mem_kind_e'(mem_type);
                        size_q  <= size_mb;
                        flags_q <= '0;
                        state   <= ST_CALC;
                    end
                end
                ST_CALC: begin
                    geom_q  <= geom_n;
                    flags_q <= flags_n;
                    wr_addr <= '0;
                    sum_q   <= '0;
                    state   <= flags_n.too_small ? ST_FIN : ST_FILL;
                end
                ST_FILL: begin
                    if (wr_addr < CSUM_ADDR) sum_q <= sum_q + rom_byte;
                    wr_addr <= wr_addr + ADDR_W'(1);
                    if (wr_addr == LAST_ADDR) state <= ST_FIN;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy        = (state == ST_CALC) || (state == ST_FILL);
    assign done        = (state == ST_FIN);
    assign err_small   = flags_q.too_small;
    assign warn_npow2  = flags_q.npow2;
    assign warn_retype = flags_q.retype;
    assign warn_trunc  = flags_q.trunc;

    AST_FILL_STEP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr != LAST_ADDR) |=> (wr_en && wr_addr == $past(wr_addr) + ADDR_W'(1))) else $error("fill address skipped"); // R2
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        ($rose(done) && !err_small) |-> ($past(wr_en) && $past(wr_addr) == LAST_ADDR)) else $error("done before last byte"); // R2
    AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        err_small |-> !wr_en) else $error("write during error"); // R3
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> ($stable(size_q) && $stable(kind_q))) else $error("start accepted while busy"); // R11
    AST_DONE_EXCL_BUSY: assert property (@(posedge clk) disable iff (rst)
        !(done && busy)) else $error("done and busy together"); // R2

endmodule

// File: tb/test_spd_image_gen.sv
module test_spd_image_gen;
    localparam int CLK_PERIOD = 10;
    localparam int SIZE_W     = 20;
    localparam int ADDR_W     = 8;
    localparam int NBYTES     = 256;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [1:0]        mem_type = 2'd0;
    logic [SIZE_W-1:0] size_mb = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [7:0]        rd_data;
    logic              busy, done, err_small, warn_npow2, warn_retype, warn_trunc;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0] exp_img [NBYTES];
    logic       e_small, e_npow2, e_retype, e_trunc;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spd_image_gen #(.SIZE_W(SIZE_W), .ADDR_W(ADDR_W)) i_spd_image_gen (
        .clk(clk), .rst(rst), .start(start), .mem_type(mem_type), .size_mb(size_mb),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .done(done),
        .err_small(err_small), .warn_npow2(warn_npow2),
        .warn_retype(warn_retype), .warn_trunc(warn_trunc)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reference model written from the requirement text.
    task automatic model(input int kind_in, input int size);
        int kind, mn, mx, lg, lg0, nb, d, dens, sum;
        e_small = 0; e_npow2 = 0; e_retype = 0; e_trunc = 0;
        if (size < 4) begin
            e_small = 1;
            return;
        end
        kind = (kind_in == 3) ? 2 : kind_in;
        lg = 0;
        while ((1 << (lg + 1)) <= size) lg++;
        lg0 = lg;
        e_npow2 = (size != (1 << lg));
        mn = (kind == 0) ? 2 : (kind == 1) ? 5 : 7;
        if (lg < mn) begin
            e_retype = 1;
            kind = (size >= 32) ? 1 : 0;
        end
        mn = (kind == 0) ? 2 : (kind == 1) ? 5 : 7;
        mx = (kind == 0) ? 9 : (kind == 1) ? 12 : 14;
        nb = 1;
        while (lg > mx && nb < 8) begin
            lg--;
            nb++;
        end
        e_trunc = (longint'(1) << lg0) > ((longint'(1) << lg) * nb);
        if (nb == 1 && lg > mn) begin
            lg--;
            nb = 2;
        end
        d = 1 << (lg - 2);
        if (kind == 2)      dens = (d & 'hE0) | ((d >> 8) & 'h1F);
        else if (kind == 1) dens = (d & 'hF8) | ((d >> 8) & 'h07);
        else                dens = d & 'hFF;
        for (int i = 0; i < NBYTES; i++) exp_img[i] = 8'd0;
        exp_img[0] = 128; exp_img[1] = 8;
        exp_img[2] = (kind == 0) ? 4 : (kind == 1) ? 7 : 8;
        exp_img[3] = 13; exp_img[4] = 10;
        exp_img[5] = 8'((kind == 2) ? nb - 1 : nb);
        exp_img[6] = 64; exp_img[8] = 4; exp_img[9] = 'h25; exp_img[10] = 1;
        exp_img[12] = 'h82; exp_img[13] = 8;
        exp_img[15] = (kind == 2) ? 0 : 1;
        exp_img[16] = 12; exp_img[17] = 4; exp_img[18] = 12;
        exp_img[19] = (kind == 2) ? 0 : 1;
        exp_img[20] = 2; exp_img[23] = 'h12;
        exp_img[27] = 20; exp_img[28] = 15; exp_img[29] = 20; exp_img[30] = 45;
        exp_img[31] = 8'(dens);
        exp_img[32] = 20; exp_img[33] = 8; exp_img[34] = 20; exp_img[35] = 8;
        sum = 0;
        for (int i = 0; i < 63; i++) sum += exp_img[i];
        exp_img[63] = 8'(sum);
    endtask

    task automatic read_byte(input int a, output logic [7:0] v);
        @(negedge clk);
        rd_addr = ADDR_W'(a);
        @(posedge clk);
        @(negedge clk);
        v = rd_data;
    endtask

    task automatic compare_image(input string tag);
        logic [7:0] v;
        int bad;
        bad = 0;
        for (int i = 0; i < NBYTES; i++) begin
            read_byte(i, v);
            if (v !== exp_img[i] && bad == 0) begin
                bad = 1;
                $display("FAIL %s image byte %0d: actual %0d expected %0d", tag, i, v, exp_img[i]);
            end
        end
        n_checks++;
        if (bad != 0) n_fail++;
    endtask

    // Start a build; optionally pulse a second start mid-run.
    task automatic run(input int kind, input int size, input int cyc_exp,
                       input bit inject, input string tag);
        int cnt;
        @(negedge clk);
        mem_type = 2'(kind);
        size_mb  = SIZE_W'(size);
        start    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check("R2", {tag, " busy after start"}, busy, 1);
        model(kind, size);
        cnt = 0;
        while (cnt < 400) begin
            if (inject && cnt == 40) begin
                mem_type = 2'd2;
                size_mb  = SIZE_W'(16384);
                start    = 1'b1;
            end
            @(posedge clk);
            cnt++;
            @(negedge clk);
            start = 1'b0;
            if (done) break;
        end
        check("R2", {tag, " edges to done"}, cnt, cyc_exp);
        check("R2", {tag, " busy low at done"}, busy, 0);
        check("R3", {tag, " err_small"}, err_small, e_small);
        check("R4", {tag, " warn_npow2"}, warn_npow2, e_npow2);
        check("R5", {tag, " warn_retype"}, warn_retype, e_retype);
        check("R6", {tag, " warn_trunc"}, warn_trunc, e_trunc);
        compare_image({tag, " R9 R10 R12"});
    endtask

    task automatic t_reset;
        check("R1", "busy", busy, 0);
        check("R1", "done", done, 0);
        check("R1", "err_small", err_small, 0);
        check("R1", "warn_npow2", warn_npow2, 0);
        check("R1", "warn_retype", warn_retype, 0);
        check("R1", "warn_trunc", warn_trunc, 0);
    endtask

    task automatic t_basic;      run(0, 64, 257, 0, "R9 SDR 64MB"); endtask
    task automatic t_npow2;      run(1, 100, 257, 0, "R4 DDR 100MB"); endtask
    task automatic t_retype_up;  run(2, 64, 257, 0, "R5 DDR2 64MB to DDR"); endtask
    task automatic t_retype_dn;  run(2, 16, 257, 0, "R5 DDR2 16MB to SDR"); endtask
    task automatic t_ddr2_fold;
        run(2, 16384, 257, 0, "R8 DDR2 16GB");
        check("R8", "DDR2 folded density", exp_img[31], 8'h08);
        check("R7", "DDR2 split banks-1", exp_img[5], 1);
    endtask
    task automatic t_ddr_fold;   run(1, 8192, 257, 0, "R8 DDR 8GB"); endtask
    task automatic t_trunc;      run(0, 4096, 257, 0, "R6 SDR 4GB four banks"); endtask
    task automatic t_cap;
        run(0, 131072, 257, 0, "R6 SDR 128GB bank cap");
        check("R6", "capped bank count", exp_img[5], 8);
    endtask
    task automatic t_nosplit;    run(0, 1024, 257, 0, "R7 SDR 1GB"); endtask
    task automatic t_small;      run(0, 3, 1, 0, "R3 size 3MB"); endtask
    task automatic t_rsv;        run(3, 128, 257, 0, "R5 code 3 as DDR2"); endtask
    task automatic t_busy_start; run(0, 64, 257, 1, "R11 restart ignored"); endtask

    task automatic t_read_latency;
        logic [7:0] v;
        @(negedge clk);
        rd_addr = 8'd0;
        @(posedge clk);
        @(negedge clk);
        rd_addr = 8'd3;
        v = rd_data;
        check("R12", "byte 0 one edge after address", v, exp_img[0]);
        @(posedge clk);
        @(negedge clk);
        check("R12", "byte 3 one edge after address", rd_data, exp_img[3]);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_read_latency();
        t_npow2();
        t_retype_up();
        t_retype_dn();
        t_ddr2_fold();
        t_ddr_fold();
        t_trunc();
        t_cap();
        t_nosplit();
        t_small();
        t_rsv();
        t_busy_start();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule